// File: doc/BRIEF.md
# Iterative 16-bit-Half Feistel Encryptor

This block scrambles a 32-bit word, for example an identifier printed on a parking ticket, with a Feistel network modelled on the Tiny Encryption Algorithm but narrowed to two 16-bit halves. One round datapath holds nine 16-bit adders and two three-input XOR mixers. A small controller uses that datapath once per clock, so a full encryption takes one clock per round. The only storage is the two half registers and a running round sum.

To use the block, present a plaintext word and a 64-bit key, then pulse `start` for one cycle while the block is idle. `done_o` pulses once when the ciphertext is ready. The ciphertext stays on `cipher_o` until the next accepted start. The key is not captured, so it must be held steady from the start pulse until `done_o`.

Top module: `feistel16_enc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block returns to idle and clears both halves and the running sum. After that edge `cipher_o` reads 0 and `done_o` reads 0.
- R2: A `start` sampled high while idle loads the plaintext and clears the sum. `done_o` is then high in the 33rd cycle after the start edge, counting the cycle right after that edge as the first: 32 round cycles, then one done cycle.
- R3: `done_o` is high for exactly one cycle per encryption.
- R4: The result matches the reference. First set y = `plain_i[31:16]` and z = `plain_i[15:0]`. Then, 32 times: s = s + 0x9E37; y = y + (((z<<4)+k0) ^ (z+s) ^ ((z>>5)+k1)); z = z + (((y<<4)+k2) ^ (y+s) ^ ((y>>5)+k3)). The right shift is logical, and the second update uses the new y.
- R5: Every addition wraps modulo 2^16, and the carry out of bit 15 is discarded.
- R6: The subkeys are taken from the key as k0 = `key_i[63:48]`, k1 = `key_i[47:32]`, k2 = `key_i[31:16]` and k3 = `key_i[15:0]`. The result is `cipher_o` = {y, z}.
- R7: A `start` that arrives during the round cycles or in the done cycle is ignored. It changes neither the result nor the cycle in which `done_o` rises, and it starts no new run.
- R8: Once `done_o` has pulsed, `cipher_o` holds its value until the next accepted start.
- R9: The sum is cleared at every start, so encrypting the same word twice under the same key gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an encryption; taken only when idle |
| plain_i | input | 32 | Plaintext word, sampled on the accepted start |
| key_i | input | 64 | Four 16-bit subkeys; hold stable while running |
| cipher_o | output | 32 | Ciphertext {y, z}; valid from done onward |
| done_o | output | 1 | One-cycle pulse when the result is ready |

## Verification
The assertions check the control behaviour on every cycle:
- `done_o` never lasts more than one cycle.
- It only follows round cycles.
- A run only begins after a start.
- Each run lasts exactly 32 rounds, which an in-checker counter measures.
- `cipher_o` is frozen whenever the block is not running and no start is taken.

The correctness of the cipher value itself can only be shown by the bench scenarios. These compare against a reference model over random words and keys and over the all-zero and all-ones corners. They also cover the subkey packing, repeat runs with the same inputs, and stray start pulses injected mid-run and during the done cycle.

// File: rtl/feistel16_pkg.sv
// Shared constants and the controller state type for the 16-bit-half
// Feistel encryptor. Assumes nothing beyond IEEE 1800-2017.
package feistel16_pkg;
    localparam int          HALF_W_DEF = 16;
    localparam int          ROUNDS_DEF = 32;
    localparam int          SHL_DEF    = 4;
    localparam int          SHR_DEF    = 5;
    localparam logic [15:0] DELTA_DEF  = 16'h9E37;
    localparam int          NKEYS      = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } ctrl_state_t;
endpackage

// File: rtl/feistel16_half.sv
// One half-update: acc + (((oth<<SHL)+ka) ^ (oth+sum) ^ ((oth>>SHR)+kb)).
// Purely combinational; four adders and one three-input XOR.
// Assumes all operands share width W and that the right shift is logical.
module feistel16_half #(
    parameter int W   = feistel16_pkg::HALF_W_DEF,
    parameter int SHL = feistel16_pkg::SHL_DEF,
    parameter int SHR = feistel16_pkg::SHR_DEF
) (
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] oth_i,
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] ka_i,
    input  logic [W-1:0] kb_i,
    output logic [W-1:0] acc_o
);
    logic [W-1:0] t_left;
    logic [W-1:0] t_mid;
    logic [W-1:0] t_right;
    logic [W-1:0] t_mix;

    // Form the three mixing operands, XOR them, and accumulate (mod 2^W).
    always_comb begin
        t_left  = (oth_i << SHL) + ka_i;
        t_mid   = oth_i + sum_i;
        t_right = (oth_i >> SHR) + kb_i;
        t_mix   = t_left ^ t_mid ^ t_right;
        acc_o   = acc_i + t_mix;
    end
endmodule

// File: rtl/feistel16_round.sv
// One complete round: advance the sum, update y from z with subkeys 0/1,
// then update z from the new y with subkeys 2/3. Nine adders in total.
// Combinational; assumes the caller registers the results.
module feistel16_round #(
    parameter int          W     = feistel16_pkg::HALF_W_DEF,
    parameter int          SHL   = feistel16_pkg::SHL_DEF,
    parameter int          SHR   = feistel16_pkg::SHR_DEF,
    parameter logic [15:0] DELTA = feistel16_pkg::DELTA_DEF
) (
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] z_i,
    input  logic [W-1:0] sum_i,
    input  logic [W-1:0] k0_i,
    input  logic [W-1:0] k1_i,
    input  logic [W-1:0] k2_i,
    input  logic [W-1:0] k3_i,
    output logic [W-1:0] y_o,
    output logic [W-1:0] z_o,
    output logic [W-1:0] sum_o
);
    // Advance the running sum by the round constant (ninth adder).
    always_comb sum_o = sum_i + W'(DELTA);

    feistel16_half #(.W(W), .SHL(SHL), .SHR(SHR)) u_half_y (
        .acc_i (y_i),
        .oth_i (z_i),
        .sum_i (sum_o),
        .ka_i  (k0_i),
        .kb_i  (k1_i),
        .acc_o (y_o)
    );

    feistel16_half #(.W(W), .SHL(SHL), .SHR(SHR)) u_half_z (
        .acc_i (z_i),
        .oth_i (y_o),
        .sum_i (sum_o),
        .ka_i  (k2_i),
        .kb_i  (k3_i),
        .acc_o (z_o)
    );
endmodule

// File: rtl/feistel16_ctrl.sv
// Sequencing FSM: IDLE -> RUN (ROUNDS cycles) -> DONE (one cycle) -> IDLE.
// A start is honoured only in IDLE. Synchronous active-low reset.
module feistel16_ctrl #(
    parameter int ROUNDS = feistel16_pkg::ROUNDS_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic done_o
);
    import feistel16_pkg::*;

    localparam int CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

    ctrl_state_t      state_q;
    logic [CNT_W-1:0] rnd_q;

    // Decode the controls the datapath needs from the current state.
    always_comb begin
        load_o = (state_q == ST_IDLE) && start_i;
        step_o = (state_q == ST_RUN);
        done_o = (state_q == ST_DONE);
    end

    // Advance the state and the round counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rnd_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    rnd_q <= '0;
                    if (start_i) state_q <= ST_RUN;
                end
                ST_RUN: begin
                    rnd_q <= rnd_q + 1'b1;
                    if (rnd_q == LAST) state_q <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/feistel16_state.sv
// Half registers and running sum with their load/feedback selection:
// load takes the fresh word and a zero sum, step takes the round results.
// Synchronous active-low reset clears everything.
module feistel16_state #(
    parameter int W = feistel16_pkg::HALF_W_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic           step_i,
    input  logic [2*W-1:0] word_i,
    input  logic [W-1:0]   y_nx_i,
    input  logic [W-1:0]   z_nx_i,
    input  logic [W-1:0]   sum_nx_i,
    output logic [W-1:0]   y_o,
    output logic [W-1:0]   z_o,
    output logic [W-1:0]   sum_o
);
    // Hold, load or advance the block halves and the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_o   <= '0;
            z_o   <= '0;
            sum_o <= '0;
        end else if (load_i) begin
            {y_o, z_o} <= word_i;
            sum_o      <= '0;
        end else if (step_i) begin
            y_o   <= y_nx_i;
            z_o   <= z_nx_i;
            sum_o <= sum_nx_i;
        end
    end
endmodule

// File: rtl/feistel16_enc.sv
// Top of the iterative encryptor: one round per clock for ROUNDS clocks.
// Assumes key_i is held stable from the accepted start until done_o.
module feistel16_enc #(
    parameter int          HALF_W = feistel16_pkg::HALF_W_DEF,
    parameter int          ROUNDS = feistel16_pkg::ROUNDS_DEF,
    parameter logic [15:0] DELTA  = feistel16_pkg::DELTA_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2*HALF_W-1:0]   plain_i,
    input  logic [4*HALF_W-1:0]   key_i,
    output logic [2*HALF_W-1:0]   cipher_o,
    output logic                  done_o
);
    import feistel16_pkg::*;

    logic [HALF_W-1:0] subkey [NKEYS];
    logic [HALF_W-1:0] y_q, z_q, sum_q;
    logic [HALF_W-1:0] y_nx, z_nx, sum_nx;
    logic              load_w;
    logic              busy_w;

    // Split the key; subkey 0 is the most significant slice.
    for (genvar gi = 0; gi < NKEYS; gi++) begin : g_key
        assign subkey[gi] = key_i[(NKEYS-gi)*HALF_W-1 -: HALF_W];
    end

    feistel16_ctrl #(.ROUNDS(ROUNDS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .load_o  (load_w),
        .step_o  (busy_w),
        .done_o  (done_o)
    );

    feistel16_round #(.W(HALF_W), .DELTA(DELTA)) u_round (
        .y_i   (y_q),
        .z_i   (z_q),
        .sum_i (sum_q),
        .k0_i  (subkey[0]),
        .k1_i  (subkey[1]),
        .k2_i  (subkey[2]),
        .k3_i  (subkey[3]),
        .y_o   (y_nx),
        .z_o   (z_nx),
        .sum_o (sum_nx)
    );

    feistel16_state #(.W(HALF_W)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .step_i   (busy_w),
        .word_i   (plain_i),
        .y_nx_i   (y_nx),
        .z_nx_i   (z_nx),
        .sum_nx_i (sum_nx),
        .y_o      (y_q),
        .z_o      (z_q),
        .sum_o    (sum_q)
    );

    // Present the block halves as the ciphertext word.
    always_comb cipher_o = {y_q, z_q};
endmodule

// File: rtl/feistel16_enc_chk.sv
// Protocol checker for feistel16_enc; observes ports and the run flag.
// Run length is measured with a counter, not a parameter-sized delay.
module feistel16_enc_chk #(
    parameter int ROUNDS = feistel16_pkg::ROUNDS_DEF,
    parameter int DW     = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] cipher
);
    localparam int LW = $clog2(ROUNDS + 1) + 1;
    logic [LW-1:0] run_len;

    // Count consecutive run cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R2
    AST_RUN_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R2
    AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done && run_len == LW'(ROUNDS))); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(cipher)); // R8
endmodule

bind feistel16_enc feistel16_enc_chk #(.ROUNDS(ROUNDS), .DW(2*HALF_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy_w),
    .done   (done_o),
    .cipher (cipher_o)
);

// File: tb/feistel16_enc_tb.sv
`timescale 1ns/1ps
module feistel16_enc_tb;
    localparam int ROUNDS = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] plain_i = '0;
    logic [63:0] key_i = '0;
    logic [31:0] cipher_o;
    logic        done_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    feistel16_enc u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .plain_i  (plain_i),
        .key_i    (key_i),
        .cipher_o (cipher_o),
        .done_o   (done_o)
    );

    // Reference model taken from the requirement text.
    function automatic logic [31:0] ref_enc(logic [31:0] p, logic [63:0] k);
        logic [15:0] y, z, s, k0, k1, k2, k3;
        y = p[31:16]; z = p[15:0]; s = '0;
        k0 = k[63:48]; k1 = k[47:32]; k2 = k[31:16]; k3 = k[15:0];
        for (int r = 0; r < ROUNDS; r++) begin
            s = s + 16'h9E37;
            y = y + ((16'(z << 4) + k0) ^ (z + s) ^ ((z >> 5) + k1));
            z = z + ((16'(y << 4) + k2) ^ (y + s) ^ ((y >> 5) + k3));
        end
        return {y, z};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One encryption; poke_at>=1 pulses a stray start at that run cycle,
    // poke_done pulses a stray start in the done cycle.
    task automatic run_one(string req, logic [31:0] p, logic [63:0] k,
                           int poke_at, bit poke_done);
        int lat;
        logic [31:0] exp;
        logic [31:0] held;
        exp = ref_enc(p, k);
        @(negedge clk);
        plain_i = p; key_i = k; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done_o && lat < 100) begin
            start = (lat == poke_at);
            if (lat == poke_at) plain_i = ~p;
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        check({req, " R2 latency"}, 32'(lat), 32'(ROUNDS + 1));
        check({req, " R4 result"}, cipher_o, exp);
        held = cipher_o;
        if (poke_done) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({req, " R3 done pulse"}, {31'd0, done_o}, 32'd0);
        repeat (4) @(negedge clk);
        check({req, " R8 held"}, cipher_o, held);
        if (poke_done) check({req, " R7 no restart"}, {31'd0, done_o}, 32'd0);
    endtask

    initial begin
        logic [31:0] first;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset cipher", cipher_o, 32'd0);
        check("R1 reset done", {31'd0, done_o}, 32'd0);
        rst_n = 1'b1;

        run_one("zero", 32'h0, 64'h0, -1, 1'b0);
        run_one("R5 ones", 32'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, -1, 1'b0);
        run_one("R6 k0 only", 32'h1234_5678, 64'hA5A5_0000_0000_0000, -1, 1'b0);
        run_one("R6 k3 only", 32'h1234_5678, 64'h0000_0000_0000_5A5A, -1, 1'b0);
        run_one("R7 mid", 32'hCAFE_F00D, 64'h0123_4567_89AB_CDEF, 10, 1'b0);
        run_one("R7 done", 32'hBEEF_0001, 64'h1111_2222_3333_4444, -1, 1'b1);

        run_one("R9 first", 32'h0BAD_C0DE, 64'hDEAD_BEEF_0000_FFFF, -1, 1'b0);
        first = cipher_o;
        run_one("R9 second", 32'h0BAD_C0DE, 64'hDEAD_BEEF_0000_FFFF, -1, 1'b0);
        check("R9 repeat", cipher_o, first);

        for (int i = 0; i < 20; i++) begin
            run_one("rand", $urandom, {$urandom, $urandom},
                    ((i % 4) == 0) ? int'($urandom_range(1, ROUNDS)) : -1,
                    (i % 5) == 1);
        end

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", cipher_o, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule